// File: doc/BRIEF.md
# Readout Busy Controller

This block decides, cycle by cycle, whether the detector readout can accept another trigger, and drives one BUSY level back to the central trigger processor. It keeps two credit counters. One counts free front-end event buffers and the other counts free readout ping-pong slots (two of them). A run-start pulse loads both counters. Decoded trigger pulses then raise and release BUSY, and take credits away from the counters. A merged stream of end-of-transfer pulses from the readout links gives credits back.

BUSY rises when a level-1 accept arrives that includes this detector. It falls when the level-2 decision arrives: always on a reject, and on an accept only if a front-end buffer is still free. If no buffer is free at a level-2 accept, BUSY stays high. It then clears by itself once returned buffers make the free count nonzero. Both counters saturate at zero and at their loaded value. Any attempt to push a counter past either bound sets a sticky error flag. The counter values and the flag are brought out for monitoring.

Top module: `readout_busy_ctrl`

## Requirements
- R1: After reset, and one cycle after a `run_init_i` pulse, `fe_free_o` equals FE_BUFS, `pp_free_o` equals 2, `busy_o` is 0 and `err_o` is 0. `run_init_i` takes priority over every other input in the same cycle.
- R2: A level-1 pulse with `l1_in_mask_i` high sets `busy_o` to 1 on the next cycle. A level-1 pulse with the mask flag low has no effect on `busy_o`.
- R3: A level-2 reject pulse, with no masked level-1 pulse in the same cycle, clears `busy_o` on the next cycle.
- R4: A level-2 accept pulse, with no masked level-1 pulse and no reject in the same cycle, clears `busy_o` on the next cycle if `fe_free_o` was nonzero in the cycle of the pulse. Otherwise it sets or holds `busy_o` at 1.
- R5: A level-2 accept pulse without end-of-transfer decrements `fe_free_o` and `pp_free_o` by one each on the next cycle.
- R6: An end-of-transfer pulse without level-2 accept increments `fe_free_o` and `pp_free_o` by one each on the next cycle.
- R7: An end-of-transfer pulse and a level-2 accept pulse in the same cycle leave both counters unchanged and do not set `err_o`.
- R8: A decrement at 0 or an increment at the loaded value leaves that counter unchanged and sets `err_o`. `err_o` then stays 1 until reset or `run_init_i`.
- R9: If `busy_o` is held after a level-2 accept found no free buffer, and no masked level-1 pulse has arrived since, then `busy_o` clears on the cycle after `fe_free_o` becomes nonzero.
- R10: A masked level-1 pulse in the same cycle as a level-2 reject or accept leaves `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_init_i | input | 1 | Run-start pulse, reloads counters and clears state |
| l1a_i | input | 1 | Level-1 accept pulse |
| l1_in_mask_i | input | 1 | This detector is in the level-1 trigger mask |
| l2r_i | input | 1 | Level-2 reject pulse |
| l2a_i | input | 1 | Level-2 accept pulse |
| eot_i | input | 1 | Merged end-of-transfer pulse |
| busy_o | output | 1 | BUSY level to the trigger processor |
| fe_free_o | output | $clog2(FE_BUFS+1) | Free front-end buffer count |
| pp_free_o | output | 2 | Free ping-pong slot count |
| err_o | output | 1 | Sticky counter bound violation |

## Verification
Every result is held in a register, so `busy_o`, both counts and `err_o` all reflect a pulse one clock edge after it. The only exception is the self-release of a held BUSY. It needs a first edge to raise the count and a second edge to drop BUSY, so it comes two edges after the end-of-transfer pulse. The bench drives each pulse on a falling edge and removes it at the next falling edge. It then compares all outputs at that point, which is half a cycle after the edge that registered the pulse. The self-release is checked after one extra idle step. A bench-side model, written from the requirements, predicts every output after every step. It is applied across all 32 input combinations from each reachable free-buffer count, and then across a long pseudo-random stream.

// File: rtl/readout_busy_pkg.sv
// Package: shared constants and types for the readout busy controller.
// Assumes: nothing beyond IEEE 1800-2017.
package readout_busy_pkg;

    // Number of readout ping-pong slots; fixed by the readout structure.
    localparam int unsigned PP_SLOTS = 2;
    localparam int unsigned PP_W     = $clog2(PP_SLOTS + 1);

    // Why BUSY is currently what it is.
    typedef enum logic [1:0] {
        ST_ALIVE = 2'd0,   // ready for triggers
        ST_EVENT = 2'd1,   // masked L1 seen, waiting for the L2 decision
        ST_FULL  = 2'd2    // L2 accept found no free front-end buffer
    } busy_state_e;

endpackage

// File: rtl/busy_credit_counter.sv
// Module: saturating credit counter, reloaded to MAX_VAL on reset or load.
// Assumes: inc and dec are single-cycle pulses; inc and dec together cancel.
// bound_hit pulses combinationally when a step would cross 0 or MAX_VAL.
module busy_credit_counter #(
    parameter int unsigned MAX_VAL = 4,
    parameter int unsigned WIDTH   = $clog2(MAX_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    input  logic             dec,
    output logic [WIDTH-1:0] count,
    output logic             bound_hit
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(MAX_VAL);

    logic step_up;
    logic step_dn;
    logic at_top;
    logic at_zero;

    // Purpose: resolve the net step and detect bound violations.
    always_comb begin
        step_up   = inc & ~dec;
        step_dn   = dec & ~inc;
        at_top    = (count == TOP);
        at_zero   = (count == '0);
        bound_hit = ~load & ((step_up & at_top) | (step_dn & at_zero));
    end

    // Purpose: hold the credit count, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            count <= TOP;
        end else if (step_up && !at_top) begin
            count <= count + 1'b1;
        end else if (step_dn && !at_zero) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/busy_state_fsm.sv
// Module: BUSY state machine driven by decoded trigger pulses.
// Assumes: pulses are single-cycle; fe_avail reflects the registered
// front-end free count in the same cycle. Priority: load, masked L1,
// L2 reject, L2 accept, then self-release from ST_FULL.
module busy_state_fsm
    import readout_busy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        l1_hit,
    input  logic        l2_rej,
    input  logic        l2_acc,
    input  logic        fe_avail,
    output logic        busy,
    output busy_state_e state
);

    busy_state_e state_nx;

    // Purpose: choose the next BUSY state from the trigger pulses.
    always_comb begin
        state_nx = state;
        if (l1_hit) begin
            state_nx = ST_EVENT;
        end else if (l2_rej) begin
            state_nx = ST_ALIVE;
        end else if (l2_acc) begin
            state_nx = fe_avail ? ST_ALIVE : ST_FULL;
        end else if (state == ST_FULL && fe_avail) begin
            state_nx = ST_ALIVE;
        end
    end

    // Purpose: register the state; load and reset return to alive.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            state <= ST_ALIVE;
        end else begin
            state <= state_nx;
        end
    end

    // Purpose: BUSY is high in every state except alive.
    always_comb busy = (state != ST_ALIVE);

endmodule

// File: rtl/readout_busy_ctrl.sv
// Module: readout busy controller top. Tracks free front-end buffers and
// ping-pong slots, drives BUSY, and latches a sticky bound-violation flag.
// Assumes: all inputs are single-cycle pulses synchronous to clk; the
// end-of-transfer stream is already merged across links.
module readout_busy_ctrl
    import readout_busy_pkg::*;
#(
    parameter int unsigned FE_BUFS = 4,
    localparam int unsigned FE_W   = $clog2(FE_BUFS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_init_i,
    input  logic            l1a_i,
    input  logic            l1_in_mask_i,
    input  logic            l2r_i,
    input  logic            l2a_i,
    input  logic            eot_i,
    output logic            busy_o,
    output logic [FE_W-1:0] fe_free_o,
    output logic [PP_W-1:0] pp_free_o,
    output logic            err_o
);

    logic        l1_hit;
    logic        fe_bound;
    logic        pp_bound;
    busy_state_e bstate;

    // Purpose: qualify L1 with the trigger-mask flag.
    always_comb l1_hit = l1a_i & l1_in_mask_i & ~run_init_i;

    busy_credit_counter #(.MAX_VAL(FE_BUFS), .WIDTH(FE_W)) u_fe_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (run_init_i),
        .inc       (eot_i),
        .dec       (l2a_i),
        .count     (fe_free_o),
        .bound_hit (fe_bound)
    );

    busy_credit_counter #(.MAX_VAL(PP_SLOTS), .WIDTH(PP_W)) u_pp_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (run_init_i),
        .inc       (eot_i),
        .dec       (l2a_i),
        .count     (pp_free_o),
        .bound_hit (pp_bound)
    );

    busy_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run_init_i),
        .l1_hit   (l1_hit),
        .l2_rej   (l2r_i),
        .l2_acc   (l2a_i),
        .fe_avail (fe_free_o != '0),
        .busy     (busy_o),
        .state    (bstate)
    );

    // Purpose: sticky error on any counter bound violation.
    always_ff @(posedge clk) begin
        if (!rst_n || run_init_i) begin
            err_o <= 1'b0;
        end else if (fe_bound || pp_bound) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/readout_busy_chk.sv
// Module: assertion checker for readout_busy_ctrl, attached by bind below.
// Assumes: observes only the top-level ports.
module readout_busy_chk #(
    parameter int unsigned FE_BUFS = 4,
    localparam int unsigned FE_W   = $clog2(FE_BUFS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_init_i,
    input logic            l1a_i,
    input logic            l1_in_mask_i,
    input logic            l2r_i,
    input logic            l2a_i,
    input logic            eot_i,
    input logic            busy_o,
    input logic [FE_W-1:0] fe_free_o,
    input logic [1:0]      pp_free_o,
    input logic            err_o
);

    // R1
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_init_i |=> (fe_free_o == FE_W'(FE_BUFS)) && (pp_free_o == 2'd2)
                       && !busy_o && !err_o);

    // R2
    l1_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a_i && l1_in_mask_i && !run_init_i) |=> busy_o);

    // R3
    l2r_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2r_i && !(l1a_i && l1_in_mask_i) && !run_init_i) |=> !busy_o);

    // R4
    l2a_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2a_i && !l2r_i && !(l1a_i && l1_in_mask_i) && !run_init_i
         && fe_free_o == '0) |=> busy_o);

    // R5
    l2a_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2a_i && !eot_i && !run_init_i && fe_free_o != '0)
        |=> fe_free_o == FE_W'($past(fe_free_o) - 1'b1));

    // R7
    net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2a_i && eot_i && !run_init_i && !err_o)
        |=> $stable(fe_free_o) && $stable(pp_free_o) && !err_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !run_init_i) |=> err_o);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_free_o <= FE_W'(FE_BUFS)) && (pp_free_o <= 2'd2));

endmodule

bind readout_busy_ctrl readout_busy_chk #(.FE_BUFS(FE_BUFS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_init_i   (run_init_i),
    .l1a_i        (l1a_i),
    .l1_in_mask_i (l1_in_mask_i),
    .l2r_i        (l2r_i),
    .l2a_i        (l2a_i),
    .eot_i        (eot_i),
    .busy_o       (busy_o),
    .fe_free_o    (fe_free_o),
    .pp_free_o    (pp_free_o),
    .err_o        (err_o)
);

// File: tb/readout_busy_ctrl_tb.sv
// Bench: model-based sweep of readout_busy_ctrl with a small buffer count.
module readout_busy_ctrl_tb;

    localparam int unsigned FE_BUFS = 4;
    localparam int unsigned FE_W    = $clog2(FE_BUFS + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run_init_i = 1'b0;
    logic            l1a_i = 1'b0;
    logic            l1_in_mask_i = 1'b0;
    logic            l2r_i = 1'b0;
    logic            l2a_i = 1'b0;
    logic            eot_i = 1'b0;
    logic            busy_o;
    logic [FE_W-1:0] fe_free_o;
    logic [1:0]      pp_free_o;
    logic            err_o;

    int tests = 0;
    int fails = 0;

    // Model: expected outputs; m_st 0 alive, 1 waiting for L2, 2 held full.
    int m_fe, m_pp, m_st;
    bit m_err;

    readout_busy_ctrl #(.FE_BUFS(FE_BUFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_init_i(run_init_i),
        .l1a_i(l1a_i), .l1_in_mask_i(l1_in_mask_i), .l2r_i(l2r_i),
        .l2a_i(l2a_i), .eot_i(eot_i), .busy_o(busy_o),
        .fe_free_o(fe_free_o), .pp_free_o(pp_free_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    task automatic compare(input string tag);
        int exp_busy;
        exp_busy = (m_st != 0);
        tests++;
        if (busy_o !== 1'(exp_busy) || fe_free_o !== FE_W'(m_fe) ||
            pp_free_o !== 2'(m_pp) || err_o !== m_err) begin
            fails++;
            $display("FAIL %s: busy/fe/pp/err actual %0b/%0d/%0d/%0b expected %0d/%0d/%0d/%0b",
                     tag, busy_o, fe_free_o, pp_free_o, err_o,
                     exp_busy, m_fe, m_pp, m_err);
        end
    endtask

    // One counter step per R5, R6, R7, R8.
    task automatic model_cnt(inout int v, input int top, input bit up, input bit dn);
        if (up && !dn) begin
            if (v == top) m_err = 1'b1; else v++;
        end else if (dn && !up) begin
            if (v == 0) m_err = 1'b1; else v--;
        end
    endtask

    // Called just after a falling edge; returns after the next one.
    task automatic step(input bit a_l1, a_m, a_l2r, a_l2a, a_eot, input string tag);
        l1a_i = a_l1; l1_in_mask_i = a_m; l2r_i = a_l2r; l2a_i = a_l2a; eot_i = a_eot;
        if (a_l1 && a_m)          m_st = 1;                    // R2, R10
        else if (a_l2r)           m_st = 0;                    // R3
        else if (a_l2a)           m_st = (m_fe > 0) ? 0 : 2;   // R4
        else if (m_st == 2 && m_fe > 0) m_st = 0;              // R9
        model_cnt(m_fe, FE_BUFS, a_eot, a_l2a);
        model_cnt(m_pp, 2, a_eot, a_l2a);
        @(negedge clk);
        l1a_i = 0; l1_in_mask_i = 0; l2r_i = 0; l2a_i = 0; eot_i = 0;
        compare(tag);
    endtask

    task automatic do_init(input string tag);
        run_init_i = 1'b1;
        l2a_i = 1'b1; eot_i = 1'b1; l1a_i = 1'b1; l1_in_mask_i = 1'b1;
        @(negedge clk);
        run_init_i = 1'b0;
        l2a_i = 0; eot_i = 0; l1a_i = 0; l1_in_mask_i = 0;
        m_fe = FE_BUFS; m_pp = 2; m_st = 0; m_err = 1'b0;
        compare(tag);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        m_fe = FE_BUFS; m_pp = 2; m_st = 0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        do_init("R1 init with competing pulses");

        // R2: unmasked L1 ignored, masked L1 asserts BUSY
        step(1, 0, 0, 0, 0, "R2 L1 not in mask");
        step(1, 1, 0, 0, 0, "R2 L1 in mask");
        step(0, 0, 1, 0, 0, "R3 L2 reject releases");
        step(1, 1, 0, 0, 0, "R2 L1 in mask again");
        step(0, 0, 0, 1, 0, "R4 R5 L2 accept with free buffer");
        step(0, 0, 0, 0, 1, "R6 end of transfer returns credit");
        step(1, 1, 0, 1, 0, "R10 L1 with L2 accept keeps busy");
        step(1, 1, 1, 0, 0, "R10 L1 with L2 reject keeps busy");

        // R8 and R9: drain front end, hold, overflow, then release
        do_init("R1 reinit");
        for (int i = 0; i < FE_BUFS; i++) begin
            step(1, 1, 0, 0, 0, "R2 drain L1");
            step(0, 0, 0, 1, 0, "R4 R5 drain accept");
        end
        step(1, 1, 0, 0, 0, "R2 L1 at empty");
        step(0, 0, 0, 1, 0, "R4 R8 accept at empty holds busy");
        step(0, 0, 0, 1, 1, "R7 net zero while held");
        step(0, 0, 0, 0, 1, "R6 credit returned");
        step(0, 0, 0, 0, 0, "R9 self release");
        step(0, 0, 0, 0, 0, "R8 error stays set");
        do_init("R1 init clears error");

        // Exhaustive: every input combination from every free count
        for (int k = 0; k <= FE_BUFS; k++) begin
            for (int c = 0; c < 32; c++) begin
                do_init("R1 sweep init");
                for (int j = 0; j < FE_BUFS - k; j++)
                    step(0, 0, 0, 1, 0, "R5 sweep preset");
                step(c[0], c[1], c[2], c[3], c[4], "R2/R3/R4/R6/R7/R8/R10 sweep");
                step(0, 0, 0, 0, 0, "R9 sweep follow-up");
            end
        end

        // Long pseudo-random stream
        do_init("R1 random init");
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[1], lfsr[2], lfsr[3] & lfsr[4] & lfsr[5],
                 lfsr[6] & lfsr[7], lfsr[8] & lfsr[9] & lfsr[11],
                 "R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
            if (lfsr[15:10] == 6'h3F) do_init("R1 random reinit");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule